// File: doc/BRIEF.md
# Serial Controller Register Bank with Aliased Feature Register and Readback

This block is the processor-facing register store of a serial controller. A host reaches sixteen register indices through one access port: a write while the internal pointer is zero loads the pointer (and may carry a command), and the next access reads or writes the register that the pointer names. After that access the pointer falls back to zero. Every stored write register is held here and presented on a flat bus for the serial engines. The extended-feature byte is presented on its own bus.

Index 7 is shared by two registers. A select bit in control register 15 steers writes at that index either to the sync pattern register or to the extended-feature register. One bit of the feature register turns on extended read. With extended read on, five read indices that normally return engine status or other registers return the contents of write registers instead. A command written at pointer zero clears the feature register in one cycle. A hardware reset clears everything.

Accesses are accepted on a valid/ready handshake where ready is always high, so the host is never back-pressured. Each accepted read produces a one-cycle response pulse that cannot be stalled. A host that cannot take the response in that cycle loses it.

Top module: `serreg_bank`

## Requirements
- R1: `acc_ready` is always 1. An access is accepted on every clock edge where `acc_valid` is 1. An accepted read raises `rsp_valid` for exactly the following cycle, and `rsp_data` holds the read value then. An accepted write leaves `rsp_valid` at 0.
- R2: A write accepted while the pointer is 0 loads the pointer from `acc_wdata[3:0]`. Any access accepted while the pointer is nonzero returns the pointer to 0. A read at pointer 0 leaves it at 0.
- R3: While bit 0 of register 15 is 1, a write at index 7 stores into the feature register, and the sync register (index 7 slot of `wr_regs_o`) keeps its value.
- R4: While bit 0 of register 15 is 0, a write at index 7 stores into the sync register, and the feature register keeps its value.
- R5: Bit 7 of the feature register is always 0, whatever is written to it. The other seven bits take the written data.
- R6: With feature bit 6 set, reads at indices 9, 4, 5, 14 and 11 return write register 3, write register 4, write register 5, the feature register and write register 10, respectively.
- R7: With feature bit 6 clear, reads at indices 9, 4, 5, 14 and 11 return write register 13, `st_main_i`, `st_aux_i`, `st_misc_i` and write register 15, respectively.
- R8: Regardless of feature bit 6, reads at index 0 return `st_main_i`, index 1 returns `st_aux_i`, index 10 returns `st_misc_i`, and indices 12, 13 and 15 return the matching write registers. Indices 2, 3, 6, 7 and 8 return 0.
- R9: The feature register changes only when it is written at index 7 with the select bit set, by the clear command, or by hardware reset.
- R10: A write at pointer 0 with `acc_wdata[5:4]` = 2'b11 clears the whole feature register on that edge. All other write registers, including the sync and control registers, are left unchanged. The pointer still loads from `acc_wdata[3:0]`.
- R11: While `rst_n` is 0, all write registers, the feature register and the pointer are 0, and `rsp_valid` is 0.
- R12: `feat_o` equals the feature register. `wr_regs_o[8*i+7:8*i]` equals write register i for i = 1..15, with the sync register at slot 7. Slot 0 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| acc_valid | input | 1 | Host access request |
| acc_ready | output | 1 | Access acceptance, constant 1 |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 8 | Write data, or pointer and command at pointer 0 |
| rsp_valid | output | 1 | Read response pulse |
| rsp_data | output | 8 | Read response value |
| st_main_i | input | 8 | Primary status byte from the engines |
| st_aux_i | input | 8 | Secondary status byte from the engines |
| st_misc_i | input | 8 | Miscellaneous status byte from the engines |
| feat_o | output | 8 | Extended-feature register contents |
| wr_regs_o | output | 128 | All write registers, 8 bits per index |

## Verification
The bench walks every value of the feature byte through the aliased index. It checks that bit 7 never sticks, and that the sync slot does not move. A bank that ignored the select bit would corrupt the sync pattern, or leave the feature byte unchanged. It sweeps all sixteen read indices under both extended-read settings with distinct register patterns. This catches a swapped or missing remap entry, which would return a status byte where a write register belongs, or the reverse. It also checks that the pointer drops back to zero after each data access, that the clear command spares the other registers, and that a mid-run hardware reset moves index 7 writes back to the sync register.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
  localparam int DATA_W = 8;
  localparam int NREG   = 16;
  localparam int PTR_W  = $clog2(NREG);

  // Register indices whose behaviour other logic depends on
  localparam int IDX_SYNC = 7;
  localparam int IDX_CTRL = 15;

  // Bit positions
  localparam int SEL_BIT  = 0;  // in control register: index 7 steering
  localparam int XRD_BIT  = 6;  // in feature register: extended read
  localparam int RSVD_BIT = 7;  // in feature register: always zero

  // Command field carried in a pointer-load write
  localparam int CMD_LSB = 4;
  localparam int CMD_W   = 2;
  localparam logic [CMD_W-1:0] CMD_FEAT_CLR = 2'b11;

  typedef enum logic [3:0] {
    SRC_ZERO,
    SRC_ST_MAIN,
    SRC_ST_AUX,
    SRC_ST_MISC,
    SRC_W3,
    SRC_W4,
    SRC_W5,
    SRC_W10,
    SRC_W12,
    SRC_W13,
    SRC_W15,
    SRC_FEAT
  } rd_src_e;
endpackage

// File: rtl/serreg_ptr.sv
module serreg_ptr
  import serreg_pkg::*;
#(
  parameter int PW = PTR_W,
  parameter int CW = CMD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire_i,
  input  logic          write_i,
  input  logic [PW-1:0] ptr_d_i,
  input  logic [CW-1:0] cmd_i,
  output logic [PW-1:0] ptr_o,
  output logic          at_zero_o,
  output logic          feat_clr_o
);
  logic [PW-1:0] ptr_q;
  logic          load;

  assign at_zero_o  = (ptr_q == '0);
  assign load       = fire_i && write_i && at_zero_o;
  assign feat_clr_o = load && (cmd_i == CMD_FEAT_CLR);
  assign ptr_o      = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (load) begin
      ptr_q <= ptr_d_i;
    end else if (fire_i) begin
      ptr_q <= '0;
    end
  end

  AST_PTR_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !at_zero_o) |=> (ptr_o == '0)); // R2
  AST_PTR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && write_i && at_zero_o) |=> (ptr_o == $past(ptr_d_i))); // R2
  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_i |=> $stable(ptr_o)); // R2
endmodule

// File: rtl/serreg_wfile.sv
module serreg_wfile
  import serreg_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int NR    = NREG,
  parameter int PW    = PTR_W,
  parameter int SYNC  = IDX_SYNC,
  parameter int CTRL  = IDX_CTRL,
  parameter int SELB  = SEL_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire_i,
  input  logic [PW-1:0] ptr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          alias_sel_o,
  output logic [DW-1:0] regs_o [NR]
);
  logic alias_sel;

  assign regs_o[0]   = '0;
  assign alias_sel   = regs_o[CTRL][SELB];
  assign alias_sel_o = alias_sel;

  for (genvar i = 1; i < NR; i++) begin : g_reg
    logic [DW-1:0] q;
    logic          hit;
    if (i == SYNC) begin : g_aliased
      assign hit = wr_fire_i && (ptr_i == PW'(i)) && !alias_sel;
    end else begin : g_plain
      assign hit = wr_fire_i && (ptr_i == PW'(i));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (hit) begin
        q <= wdata_i;
      end
    end
    assign regs_o[i] = q;
  end

  AST_SYNC_HOLD_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire_i && ptr_i == PW'(SYNC) && alias_sel) |=> $stable(regs_o[SYNC])); // R3
  AST_SYNC_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire_i && ptr_i == PW'(SYNC) && !alias_sel) |=> (regs_o[SYNC] == $past(wdata_i))); // R4
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_fire_i && ptr_i == PW'(CTRL)) |=> $stable(regs_o[CTRL])); // R10
endmodule

// File: rtl/serreg_feat.sv
module serreg_feat
  import serreg_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int RSVD = RSVD_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic          clr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] feat_o
);
  localparam logic [DW-1:0] KEEP_MASK = ~(DW'(1) << RSVD);

  logic [DW-1:0] feat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      feat_q <= '0;
    end else if (clr_i) begin
      feat_q <= '0;
    end else if (we_i) begin
      feat_q <= wdata_i & KEEP_MASK;
    end
  end

  assign feat_o = feat_q;

  AST_RSVD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    feat_o[RSVD] == 1'b0); // R5
  AST_FEAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i && !clr_i) |=> $stable(feat_o)); // R9
  AST_FEAT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (feat_o == '0)); // R10
endmodule

// File: rtl/serreg_rdmux.sv
module serreg_rdmux
  import serreg_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int PW  = PTR_W,
  parameter int XRD = XRD_BIT
) (
  input  logic [PW-1:0] ptr_i,
  input  logic [DW-1:0] feat_i,
  input  logic [DW-1:0] st_main_i,
  input  logic [DW-1:0] st_aux_i,
  input  logic [DW-1:0] st_misc_i,
  input  logic [DW-1:0] w3_i,
  input  logic [DW-1:0] w4_i,
  input  logic [DW-1:0] w5_i,
  input  logic [DW-1:0] w10_i,
  input  logic [DW-1:0] w12_i,
  input  logic [DW-1:0] w13_i,
  input  logic [DW-1:0] w15_i,
  output logic [DW-1:0] rd_o
);
  rd_src_e src;
  logic    xrd;

  assign xrd = feat_i[XRD];

  always_comb begin
    unique case (ptr_i)
      PW'(0):  src = SRC_ST_MAIN;
      PW'(1):  src = SRC_ST_AUX;
      PW'(4):  src = xrd ? SRC_W4   : SRC_ST_MAIN;
      PW'(5):  src = xrd ? SRC_W5   : SRC_ST_AUX;
      PW'(9):  src = xrd ? SRC_W3   : SRC_W13;
      PW'(10): src = SRC_ST_MISC;
      PW'(11): src = xrd ? SRC_W10  : SRC_W15;
      PW'(12): src = SRC_W12;
      PW'(13): src = SRC_W13;
      PW'(14): src = xrd ? SRC_FEAT : SRC_ST_MISC;
      PW'(15): src = SRC_W15;
      default: src = SRC_ZERO;
    endcase
  end

  always_comb begin
    unique case (src)
      SRC_ST_MAIN: rd_o = st_main_i;
      SRC_ST_AUX:  rd_o = st_aux_i;
      SRC_ST_MISC: rd_o = st_misc_i;
      SRC_W3:      rd_o = w3_i;
      SRC_W4:      rd_o = w4_i;
      SRC_W5:      rd_o = w5_i;
      SRC_W10:     rd_o = w10_i;
      SRC_W12:     rd_o = w12_i;
      SRC_W13:     rd_o = w13_i;
      SRC_W15:     rd_o = w15_i;
      SRC_FEAT:    rd_o = feat_i;
      default:     rd_o = '0;
    endcase
  end
endmodule

// File: rtl/serreg_bank.sv
module serreg_bank
  import serreg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NR = NREG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  output logic             acc_ready,
  input  logic             acc_write,
  input  logic [DW-1:0]    acc_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  input  logic [DW-1:0]    st_main_i,
  input  logic [DW-1:0]    st_aux_i,
  input  logic [DW-1:0]    st_misc_i,
  output logic [DW-1:0]    feat_o,
  output logic [NR*DW-1:0] wr_regs_o
);
  localparam int PW = $clog2(NR);

  logic          fire;
  logic          wr_fire;
  logic          rd_fire;
  logic [PW-1:0] ptr;
  logic          ptr_zero;
  logic          feat_clr;
  logic          alias_sel;
  logic          feat_we;
  logic [DW-1:0] feat;
  logic [DW-1:0] regs [NR];
  logic [DW-1:0] rd_word;
  logic          rsp_v_q;
  logic [DW-1:0] rsp_d_q;

  assign acc_ready = 1'b1;
  assign fire      = acc_valid;
  assign wr_fire   = fire && acc_write && !ptr_zero;
  assign rd_fire   = fire && !acc_write;
  assign feat_we   = wr_fire && (ptr == PW'(IDX_SYNC)) && alias_sel;

  serreg_ptr #(.PW(PW), .CW(CMD_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire_i     (fire),
    .write_i    (acc_write),
    .ptr_d_i    (acc_wdata[PW-1:0]),
    .cmd_i      (acc_wdata[CMD_LSB +: CMD_W]),
    .ptr_o      (ptr),
    .at_zero_o  (ptr_zero),
    .feat_clr_o (feat_clr)
  );

  serreg_wfile #(
    .DW(DW), .NR(NR), .PW(PW), .SYNC(IDX_SYNC), .CTRL(IDX_CTRL), .SELB(SEL_BIT)
  ) u_wfile (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_fire_i   (wr_fire),
    .ptr_i       (ptr),
    .wdata_i     (acc_wdata),
    .alias_sel_o (alias_sel),
    .regs_o      (regs)
  );

  serreg_feat #(.DW(DW), .RSVD(RSVD_BIT)) u_feat (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (feat_we),
    .clr_i   (feat_clr),
    .wdata_i (acc_wdata),
    .feat_o  (feat)
  );

  serreg_rdmux #(.DW(DW), .PW(PW), .XRD(XRD_BIT)) u_rdmux (
    .ptr_i     (ptr),
    .feat_i    (feat),
    .st_main_i (st_main_i),
    .st_aux_i  (st_aux_i),
    .st_misc_i (st_misc_i),
    .w3_i      (regs[3]),
    .w4_i      (regs[4]),
    .w5_i      (regs[5]),
    .w10_i     (regs[10]),
    .w12_i     (regs[12]),
    .w13_i     (regs[13]),
    .w15_i     (regs[15]),
    .rd_o      (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else begin
      rsp_v_q <= rd_fire;
      if (rd_fire) begin
        rsp_d_q <= rd_word;
      end
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_data  = rsp_d_q;
  assign feat_o    = feat;

  for (genvar i = 0; i < NR; i++) begin : g_flat
    assign wr_regs_o[i*DW +: DW] = regs[i];
  end

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid); // R1
  AST_NO_RSP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !rsp_valid); // R1
  AST_XRD_FEAT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && ptr == PW'(14) && feat[XRD_BIT]) |=> (rsp_data == $past(feat))); // R6
  AST_XRD_W3_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && ptr == PW'(9) && feat[XRD_BIT]) |=> (rsp_data == $past(regs[3]))); // R6
  AST_PLAIN_ST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && ptr == PW'(4) && !feat[XRD_BIT]) |=> (rsp_data == $past(st_main_i))); // R7
  AST_FEAT_KEEPS_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && ptr == PW'(IDX_SYNC) && !alias_sel && !feat_clr) |=> $stable(feat_o)); // R4
endmodule

// File: tb/serreg_bank_test.sv
module serreg_bank_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         acc_valid = 1'b0;
  logic         acc_ready;
  logic         acc_write = 1'b0;
  logic [7:0]   acc_wdata = '0;
  logic         rsp_valid;
  logic [7:0]   rsp_data;
  logic [7:0]   st_main_i = 8'hA1;
  logic [7:0]   st_aux_i  = 8'hB2;
  logic [7:0]   st_misc_i = 8'hC3;
  logic [7:0]   feat_o;
  logic [127:0] wr_regs_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] m_wr [16];
  logic [7:0] m_feat;

  serreg_bank uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_write(acc_write), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .st_main_i(st_main_i), .st_aux_i(st_aux_i),
    .st_misc_i(st_misc_i), .feat_o(feat_o), .wr_regs_o(wr_regs_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int idx);
    bit x = m_feat[6];
    case (idx)
      0:  return st_main_i;
      1:  return st_aux_i;
      4:  return x ? m_wr[4]  : st_main_i;
      5:  return x ? m_wr[5]  : st_aux_i;
      9:  return x ? m_wr[3]  : m_wr[13];
      10: return st_misc_i;
      11: return x ? m_wr[10] : m_wr[15];
      12: return m_wr[12];
      13: return m_wr[13];
      14: return x ? m_feat   : st_misc_i;
      15: return m_wr[15];
      default: return 8'h00;
    endcase
  endfunction

  // One accepted access; the response is sampled on the following negedge
  task automatic acc(input bit w, input logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    chk("R1 ready", {31'd0, acc_ready}, 32'd1);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, {31'd0, !w});
    r = rsp_data;
  endtask

  task automatic wr_reg(input int idx, input logic [7:0] d);
    logic [7:0] r;
    acc(1'b1, 8'(idx), r);
    acc(1'b1, d, r);
    if (idx == 7) begin
      if (m_wr[15][0]) m_feat = d & 8'h7F;
      else m_wr[7] = d;
    end else begin
      m_wr[idx] = d;
    end
  endtask

  task automatic rd_reg(input int idx, output logic [7:0] r);
    logic [7:0] dummy;
    if (idx != 0) acc(1'b1, 8'(idx), dummy);
    acc(1'b0, 8'h00, r);
  endtask

  task automatic chk_outputs(input string req);
    chk({req, " feat_o"}, {24'd0, feat_o}, {24'd0, m_feat});
    for (int i = 0; i < 16; i++)
      chk({req, " wr_regs_o"}, {24'd0, wr_regs_o[i*8 +: 8]}, {24'd0, (i == 0) ? 8'h00 : m_wr[i]});
  endtask

  task automatic sweep(input string req);
    logic [7:0] r;
    for (int i = 0; i < 16; i++) begin
      rd_reg(i, r);
      chk(req, {24'd0, r}, {24'd0, exp_rd(i)});
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 16; i++) m_wr[i] = 8'h00;
    m_feat = 8'h00;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    model_clear();
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    chk_outputs("R11");
    rst_n = 1'b1;
    @(negedge clk);

    // Distinct patterns in every plain write register
    for (int i = 1; i < 16; i++)
      if (i != 7 && i != 15) wr_reg(i, 8'((i * 8'h1D) ^ 8'h5A));
    wr_reg(15, 8'h40);
    chk_outputs("R12 after fill");

    // R2: after a data write the pointer is back at 0, so a read gives the main status
    acc(1'b0, 8'h00, r);
    chk("R2 pointer back to 0", {24'd0, r}, {24'd0, st_main_i});
    acc(1'b0, 8'h00, r);
    chk("R2 read at 0 keeps 0", {24'd0, r}, {24'd0, st_main_i});

    // R4: select clear, index 7 reaches sync
    wr_reg(7, 8'h3C);
    chk("R4 sync written", {24'd0, wr_regs_o[56 +: 8]}, 32'h3C);
    chk("R4 feat kept", {24'd0, feat_o}, 32'h00);
    sweep("R7 plain map");

    // R3/R5: select set, index 7 reaches feature register, bit 7 dropped
    wr_reg(15, 8'h41);
    wr_reg(7, 8'hFF);
    chk("R3 sync kept", {24'd0, wr_regs_o[56 +: 8]}, 32'h3C);
    chk("R5 reserved bit low", {24'd0, feat_o}, 32'h7F);
    sweep("R6 extended map");
    wr_reg(7, 8'h2B);
    sweep("R7 plain map after disable");

    // Every feature value through the aliased index
    for (int v = 0; v < 256; v++) begin
      wr_reg(7, 8'(v));
      chk("R5 feature value", {24'd0, feat_o}, {24'd0, 8'(v) & 8'h7F});
      chk("R3 sync untouched", {24'd0, wr_regs_o[56 +: 8]}, 32'h3C);
      rd_reg(14, r);
      chk("R6/R7 index 14", {24'd0, r}, {24'd0, exp_rd(14)});
      rd_reg(9, r);
      chk("R6/R7 index 9", {24'd0, r}, {24'd0, exp_rd(9)});
      if (v % 32 == 0) sweep("R8 full map");
    end

    // R9: feature persists across other writes and a sync write
    wr_reg(7, 8'h55);
    wr_reg(3, 8'hE7);
    wr_reg(15, 8'h80);
    wr_reg(7, 8'h99);
    chk("R9 feature persists", {24'd0, feat_o}, 32'h55);
    chk("R4 sync via select clear", {24'd0, wr_regs_o[56 +: 8]}, 32'h99);
    sweep("R6 map after changes");

    // R10: clear command at pointer 0, pointer load 0
    acc(1'b1, 8'h30, r);
    m_feat = 8'h00;
    chk_outputs("R10 clear");
    wr_reg(15, 8'h01);
    wr_reg(7, 8'h46);
    // Clear command that also loads pointer 15
    acc(1'b1, 8'h3F, r);
    m_feat = 8'h00;
    chk("R10 clear with pointer", {24'd0, feat_o}, 32'h00);
    acc(1'b0, 8'h00, r);
    chk("R10 pointer loaded with clear", {24'd0, r}, 32'h01);
    chk_outputs("R10 others kept");

    // R11: hardware reset mid-run
    wr_reg(7, 8'h6E);
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    @(negedge clk);
    chk("R11 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk_outputs("R11 mid-run");
    rst_n = 1'b1;
    @(negedge clk);
    wr_reg(7, 8'hD4);
    chk("R11 index 7 back to sync", {24'd0, wr_regs_o[56 +: 8]}, 32'hD4);
    chk("R11 feature stays 0", {24'd0, feat_o}, 32'h00);
    sweep("R8 map after reset");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule